// File: doc/BRIEF.md
# Fixed-Point Linear System Solver for Optimal FIR Taps

This block solves the normal equations of a least-squares FIR design. It solves the square system R·w = p, where R is the input autocorrelation matrix and p is the cross-correlation vector, and turns the solution into filter taps. Software or a correlation stage loads an augmented matrix through a simple write port. The matrix has M rows and M+1 columns, all values in signed Q16.16, and p sits in the last column.

A start pulse begins the solve. Forward elimination uses the diagonal entry as the pivot at every step and never exchanges rows. Back substitution follows. All multiplications share one multiplier, and every division goes through one sequential divider whose latency is fixed. The controller waits for the divider's ready pulse each time.

Each solved tap is requantised to a signed 16-bit word with 12 fraction bits, saturating at the ends of that range. The taps can then be read combinationally by index. A zero pivot ends the solve early: the error flag is set, done is raised and every tap is left at zero.

Top module: `gsolve_top`

## Requirements
- R1: While idle, a write with `wr_en` high stores `wr_data` (signed Q16.16) at row `wr_row` (0..M-1) and column `wr_col` (0..M). Column M holds the right-hand side. Writes with an index outside that range change nothing.
- R2: A `start` pulse while idle raises `busy` from the next cycle and lowers `done`. `busy` then stays high until the result is ready.
- R3: When `done` is high and `err` is low, `rd_coef` for `rd_idx` = n carries tap w(n) as a signed 16-bit word with 12 fraction bits. It is within ±2 LSB of round(w(n)·4096) for diagonally dominant systems, and it is readable in the same cycle as `rd_idx`.
- R4: The pivot for step i is always A(i,i) as it stands after the earlier steps. Rows are never exchanged, so a diagonal entry that becomes zero ends the solve with an error even when the system is nonsingular.
- R5: A zero pivot, in either elimination or back substitution, sets `err` and raises `done`, and every tap then reads 0.
- R6: `done` and `err` keep their values while idle. The next accepted `start` clears both.
- R7: A tap above the range saturates to 32767 and a tap below it saturates to -32768. Taps never wrap.
- R8: While `busy` is high, `start` pulses and writes on the load port are ignored, and the result matches the matrix loaded before the start.
- R9: After reset, `busy`, `done` and `err` are 0 and every tap reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Matrix write strobe |
| wr_row | input | IW | Row index of the write |
| wr_col | input | IW | Column index of the write (M selects right-hand side) |
| wr_data | input | 32 | Matrix entry, signed Q16.16 |
| start | input | 1 | Begin a solve (accepted while idle) |
| busy | output | 1 | Solve in progress |
| done | output | 1 | Result (or error) ready, held until next start |
| err | output | 1 | Zero pivot met during last solve |
| rd_idx | input | IW | Tap index to read |
| rd_coef | output | 16 | Selected tap, signed, 12 fraction bits |

IW = $clog2(M+2).

## Verification
`busy` is due one cycle after an accepted start, so the bench checks it at the falling edge that follows the start pulse. A solve has a cost that depends on the data path: each row operation costs one issue cycle, one launch cycle and 48 divider steps, plus M+1 update cycles, and the back substitution steps add cycles of their own. For M = 4 this gives a few hundred cycles. The bench therefore polls `done` at each falling edge against a bound of 3000 cycles. It reads the taps only after `done` has been seen, waiting one time unit after setting `rd_idx`, because the read path has no register.

// File: rtl/gsolve_pkg.sv
package gsolve_pkg;
    localparam int DW = 32;   // working word width
    localparam int FB = 16;   // working fraction bits
    localparam int CW = 16;   // tap width
    localparam int CF = 12;   // tap fraction bits

    typedef enum logic [3:0] {
        S_IDLE, S_FSEL, S_FWAIT, S_FUPD, S_BACC, S_BDIV, S_BWAIT, S_QUANT, S_DONE
    } gs_state_e;

    // Requantise a Q16.16 value to the tap format with saturation.
    function automatic logic signed [CW-1:0] tap_sat(input logic signed [DW-1:0] v);
        logic signed [DW-1:0] s;
        s = v >>> (FB - CF);
        if (s > DW'(2**(CW-1) - 1))
            return CW'(2**(CW-1) - 1);
        else if (s < -DW'(2**(CW-1)))
            return {1'b1, {(CW-1){1'b0}}};
        else
            return s[CW-1:0];
    endfunction
endpackage

// File: rtl/gsolve_mul.sv
module gsolve_mul import gsolve_pkg::*; (
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] y,
    output logic signed [DW-1:0] p
);
    logic signed [2*DW-1:0] full;
    always_comb begin
        full = x * y;
        p    = DW'(full >>> FB);
    end
endmodule

// File: rtl/gsolve_div.sv
module gsolve_div import gsolve_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic signed [DW-1:0] num,
    input  logic signed [DW-1:0] den,
    output logic                 rdy,
    output logic signed [DW-1:0] q
);
    localparam int NW = DW + FB;
    localparam int CNW = $clog2(NW);

    logic [NW-1:0]  quo;
    logic [DW-1:0]  rem, dv;
    logic [DW:0]    trial;
    logic [CNW-1:0] cnt;
    logic           run, neg;

    assign trial = {rem, quo[NW-1]};
    assign q     = neg ? -$signed(quo[DW-1:0]) : $signed(quo[DW-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0; rdy <= 1'b0; neg <= 1'b0;
            quo <= '0; rem <= '0; dv <= '0; cnt <= '0;
        end else begin
            rdy <= 1'b0;
            if (go) begin
                run <= 1'b1;
                cnt <= '0;
                rem <= '0;
                neg <= num[DW-1] ^ den[DW-1];
                quo <= {(num[DW-1] ? $unsigned(-num) : $unsigned(num)), {FB{1'b0}}};
                dv  <= den[DW-1] ? $unsigned(-den) : $unsigned(den);
            end else if (run) begin
                if (trial >= {1'b0, dv}) begin
                    rem <= DW'(trial - {1'b0, dv});
                    quo <= {quo[NW-2:0], 1'b1};
                end else begin
                    rem <= trial[DW-1:0];
                    quo <= {quo[NW-2:0], 1'b0};
                end
                cnt <= cnt + 1'b1;
                if (cnt == CNW'(NW - 1)) begin
                    run <= 1'b0;
                    rdy <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/gsolve_top.sv
module gsolve_top import gsolve_pkg::*; #(
    parameter  int M  = 4,
    localparam int IW = $clog2(M + 2)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_row,
    input  logic [IW-1:0]        wr_col,
    input  logic signed [DW-1:0] wr_data,
    input  logic                 start,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    input  logic [IW-1:0]        rd_idx,
    output logic signed [CW-1:0] rd_coef
);
    localparam int NR = 2**IW;

    gs_state_e            st;
    logic signed [DW-1:0] a [NR][NR];
    logic signed [DW-1:0] w [NR];
    logic signed [CW-1:0] coef [NR];
    logic [IW-1:0]        i, j, k;
    logic signed [DW-1:0] fct, acc;
    logic signed [DW-1:0] m_x, m_y, m_p, d_num, d_q;
    logic                 div_go, div_rdy;

    assign busy    = (st != S_IDLE);
    assign rd_coef = coef[rd_idx];

    always_comb begin
        m_x   = (st == S_FUPD) ? fct : a[i][k];
        m_y   = (st == S_FUPD) ? a[i][k] : w[k];
        d_num = (st == S_FWAIT) ? a[j][i] : acc;
    end

    gsolve_mul u_mul (.x(m_x), .y(m_y), .p(m_p));

    gsolve_div u_div (
        .clk(clk), .rst(rst), .go(div_go), .num(d_num), .den(a[i][i]),
        .rdy(div_rdy), .q(d_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; done <= 1'b0; err <= 1'b0; div_go <= 1'b0;
            i <= '0; j <= '0; k <= '0; fct <= '0; acc <= '0;
            for (int r = 0; r < NR; r++) begin
                w[r]    <= '0;
                coef[r] <= '0;
                for (int c = 0; c < NR; c++) a[r][c] <= '0;
            end
        end else begin
            div_go <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (wr_en && wr_row < IW'(M) && wr_col <= IW'(M))
                        a[wr_row][wr_col] <= wr_data;
                    if (start) begin
                        done <= 1'b0; err <= 1'b0;
                        i <= '0; j <= IW'(1);
                        for (int r = 0; r < NR; r++) begin
                            w[r] <= '0; coef[r] <= '0;
                        end
                        st <= S_FSEL;
                    end
                end
                S_FSEL: begin
                    if (i == IW'(M - 1)) begin
                        acc <= a[i][M];
                        k   <= i + 1'b1;
                        st  <= S_BACC;
                    end else if (j == IW'(M)) begin
                        i <= i + 1'b1;
                        j <= i + IW'(2);
                    end else if (a[i][i] == '0) begin
                        err <= 1'b1;
                        st  <= S_DONE;
                    end else begin
                        div_go <= 1'b1;
                        st     <= S_FWAIT;
                    end
                end
                S_FWAIT: begin
                    if (div_rdy) begin
                        fct <= d_q;
                        k   <= '0;
                        st  <= S_FUPD;
                    end
                end
                S_FUPD: begin
                    a[j][k] <= a[j][k] - m_p;
                    if (k == IW'(M)) begin
                        j  <= j + 1'b1;
                        st <= S_FSEL;
                    end else begin
                        k <= k + 1'b1;
                    end
                end
                S_BACC: begin
                    if (k == IW'(M)) begin
                        st <= S_BDIV;
                    end else begin
                        acc <= acc - m_p;
                        k   <= k + 1'b1;
                    end
                end
                S_BDIV: begin
                    if (a[i][i] == '0) begin
                        err <= 1'b1;
                        st  <= S_DONE;
                    end else begin
                        div_go <= 1'b1;
                        st     <= S_BWAIT;
                    end
                end
                S_BWAIT: begin
                    if (div_rdy) begin
                        w[i] <= d_q;
                        if (i == '0) begin
                            st <= S_QUANT;
                        end else begin
                            i   <= i - 1'b1;
                            k   <= i;
                            acc <= a[i - 1'b1][M];
                            st  <= S_BACC;
                        end
                    end
                end
                S_QUANT: begin
                    for (int r = 0; r < M; r++) coef[r] <= tap_sat(w[r]);
                    st <= S_DONE;
                end
                S_DONE: begin
                    done <= 1'b1;
                    st   <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gsolve_chk.sv
module gsolve_chk import gsolve_pkg::*; (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 err,
    input logic signed [CW-1:0] rd_coef,
    input logic                 div_rdy
);
    // R2: an accepted start makes the block busy on the next cycle
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R2: busy is left only with done raised
    a_r2_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (busy || done));

    // R6: done is held while idle without a start
    a_r6_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R6: done and busy never overlap
    a_r6_done_busy_excl: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    // R5: an error outcome is always reported with done
    a_r5_err_with_done: assert property (@(posedge clk) disable iff (rst)
        (err && !busy) |-> done);

    // R5: taps read zero after an error
    a_r5_coef_zero_on_err: assert property (@(posedge clk) disable iff (rst)
        (err && !busy) |-> (rd_coef == '0));

    // R3: the divider hands back each quotient as a one-cycle pulse
    a_r3_div_single_pulse: assert property (@(posedge clk) disable iff (rst)
        div_rdy |=> !div_rdy);
endmodule

bind gsolve_top gsolve_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .err(err), .rd_coef(rd_coef), .div_rdy(div_rdy)
);

// File: tb/sim_gsolve_top.sv
`timescale 1ns/1ps
module sim_gsolve_top;
    localparam int M  = 4;
    localparam int IW = $clog2(M + 2);

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0, start = 1'b0;
    logic [IW-1:0] wr_row = '0, wr_col = '0, rd_idx = '0;
    logic signed [31:0] wr_data = '0;
    logic busy, done, err;
    logic signed [15:0] rd_coef;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    real am [M][M+1];

    always #4 clk = ~clk;

    gsolve_top #(.M(M)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
        .wr_data(wr_data), .start(start), .busy(busy), .done(done), .err(err),
        .rd_idx(rd_idx), .rd_coef(rd_coef)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int r, input int c, input real v);
        @(negedge clk);
        wr_en = 1'b1; wr_row = IW'(r); wr_col = IW'(c);
        wr_data = $rtoi(v * 65536.0);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load();
        for (int r = 0; r < M; r++)
            for (int c = 0; c <= M; c++) put(r, c, am[r][c]);
    endtask

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
        chk(done === 1'b0, "R2", "done low after start", int'(done), 0);
    endtask

    task automatic wait_done();
        int n = 0;
        while (done !== 1'b1 && n < 3000) begin
            @(negedge clk); n++;
        end
        chk(done === 1'b1, "R2", "done within bound", int'(done), 1);
    endtask

    task automatic rd(input int idx, output int v);
        rd_idx = IW'(idx); #1; v = int'(rd_coef);
    endtask

    // Reference taps: real-valued elimination, then round and clip.
    task automatic ref_taps(output int exp [M]);
        real t [M][M+1];
        real x [M];
        real f, s, q;
        for (int r = 0; r < M; r++) for (int c = 0; c <= M; c++) t[r][c] = am[r][c];
        for (int p = 0; p < M; p++)
            for (int r = p + 1; r < M; r++) begin
                f = t[r][p] / t[p][p];
                for (int c = 0; c <= M; c++) t[r][c] = t[r][c] - f * t[p][c];
            end
        for (int r = M - 1; r >= 0; r--) begin
            s = t[r][M];
            for (int c = r + 1; c < M; c++) s = s - t[r][c] * x[c];
            x[r] = s / t[r][r];
        end
        for (int r = 0; r < M; r++) begin
            q = x[r] * 4096.0;
            q = (q >= 0.0) ? q + 0.5 : q - 0.5;
            if (q > 32767.0) exp[r] = 32767;
            else if (q < -32768.0) exp[r] = -32768;
            else exp[r] = $rtoi(q);
        end
    endtask

    task automatic cmp_taps(input string req);
        int exp [M];
        int v;
        ref_taps(exp);
        chk(err === 1'b0, req, "err low", int'(err), 0);
        for (int n = 0; n < M; n++) begin
            rd(n, v);
            chk(v - exp[n] <= 2 && exp[n] - v <= 2, req, $sformatf("tap %0d", n), v, exp[n]);
        end
    endtask

    task automatic set_diag(input real d, input real b0, input real b1,
                            input real b2, input real b3);
        for (int r = 0; r < M; r++) for (int c = 0; c < M; c++) am[r][c] = (r == c) ? d : 0.0;
        am[0][M] = b0; am[1][M] = b1; am[2][M] = b2; am[3][M] = b3;
    endtask

    task automatic set_dom1();
        am[0] = '{4.0, 1.0, 0.5, 0.25, 1.0};
        am[1] = '{1.0, 5.0, 1.0, 0.5, -2.0};
        am[2] = '{0.5, 1.0, 6.0, 1.0, 3.0};
        am[3] = '{0.25, 0.5, 1.0, 3.0, 0.5};
    endtask

    task automatic t_reset();
        int v;
        chk(busy === 1'b0, "R9", "busy after reset", int'(busy), 0);
        chk(done === 1'b0, "R9", "done after reset", int'(done), 0);
        chk(err === 1'b0, "R9", "err after reset", int'(err), 0);
        for (int n = 0; n < M; n++) begin
            rd(n, v);
            chk(v == 0, "R9", "tap after reset", v, 0);
        end
    endtask

    task automatic t_identity();
        set_diag(1.0, 1.5, -0.25, 3.0, -7.5);
        load();
        put(0, M + 1, 9.0);   // R1: out-of-range column ignored
        put(M, 0, 9.0);       // R1: out-of-range row ignored
        kick(); wait_done();
        cmp_taps("R1");
    endtask

    task automatic t_dominant();
        set_dom1(); load(); kick(); wait_done(); cmp_taps("R3");
        am[0] = '{8.0, -2.0, 1.0, 0.5, -4.0};
        am[1] = '{-1.0, 7.0, 2.0, -1.0, 2.5};
        am[2] = '{2.0, 1.0, -9.0, 3.0, 1.0};
        am[3] = '{0.5, -1.5, 2.0, 6.0, -3.0};
        load(); kick(); wait_done(); cmp_taps("R3");
    endtask

    task automatic t_saturate();
        set_diag(0.5, 5.0, -5.0, 1.0, -0.125);
        load(); kick(); wait_done();
        cmp_taps("R7");
    endtask

    task automatic t_err_taps(input string req);
        int v;
        chk(err === 1'b1, req, "err set", int'(err), 1);
        chk(done === 1'b1, req, "done with err", int'(done), 1);
        for (int n = 0; n < M; n++) begin
            rd(n, v);
            chk(v == 0, req, "tap zero on err", v, 0);
        end
    endtask

    task automatic t_zero_pivot();
        set_dom1(); am[0][0] = 0.0;
        load(); kick(); wait_done();
        t_err_taps("R5");
    endtask

    task automatic t_no_swap();
        am[0] = '{1.0, 1.0, 0.0, 0.0, 1.0};
        am[1] = '{1.0, 1.0, 1.0, 0.0, 2.0};
        am[2] = '{0.0, 1.0, 1.0, 0.0, 3.0};
        am[3] = '{0.0, 0.0, 0.0, 1.0, 4.0};
        load(); kick(); wait_done();
        t_err_taps("R4");
    endtask

    task automatic t_sticky();
        repeat (20) @(negedge clk);
        chk(done === 1'b1, "R6", "done held idle", int'(done), 1);
        chk(err === 1'b1, "R6", "err held idle", int'(err), 1);
        set_dom1(); load();
        kick();
        chk(err === 1'b0, "R6", "err cleared by start", int'(err), 0);
        wait_done();
        cmp_taps("R6");
    endtask

    task automatic t_busy_ignore();
        set_dom1(); load(); kick();
        repeat (5) @(negedge clk);
        wr_en = 1'b1; wr_row = '0; wr_col = '0; wr_data = 32'sh0003_0000; start = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; start = 1'b0;
        wait_done();
        cmp_taps("R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_identity();
        t_dominant();
        t_saturate();
        t_zero_pivot();
        t_no_swap();
        t_sticky();
        t_busy_ignore();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule